// File: doc/BRIEF.md
# Cascaded Sixteen-Bit Mode-Selectable ALU

This block builds a 16-bit combinational arithmetic/logic unit from four identical 4-bit slices. The slices work side by side, each on its own nibble of the two operands. All of them take the same 4-bit function select and the same arithmetic/logic mode bit. A carry network joins the slices. It takes each slice's group propagate and generate outputs, together with the overall carry in, and forms the carry into every slice and the carry out of the whole word.

The carry network has two build-time variants. In the lookahead variant each carry is a flat two-level sum of products, so no carry waits on a preceding slice. In the ripple variant each carry is formed from the one before it. Both variants give the same results. The unit also drives the word-level propagate and generate outputs, so it can be cascaded again. It drives an all-ones flag as well. In the subtract-minus-one operation with carry in 0, that flag signals that the two operands are equal.

Top module: `alu16_cascade`

## Requirements
- R1: The select and mode apply to all four nibbles at once. The behaviour below holds across the full 16-bit word, with carries crossing nibble boundaries (for example FFFF plus 0001 gives 0000 with carry out 1).
- R2: Per bit, define H = a | (b & sel[0]) | (~b & sel[1]) and M = (a & ~b & sel[2]) | (a & b & sel[3]). With logic_mode_i = 0, {carry_o, result_o} = H + M + carry_i over 16 bits.
- R3: With logic_mode_i = 1, result_o = ~(H ^ M), and carry_i has no effect on result_o.
- R4: The following select codes give named operations. In arithmetic mode, sel 1001 gives a + b + carry_i, and sel 0110 gives a - b - 1 + carry_i. In logic mode, sel 0000 gives ~a, sel 1011 gives a & b, sel 1110 gives a | b, and sel 0110 gives a ^ b.
- R5: grp_p_o is 1 exactly when H is all ones.
- R6: grp_g_o equals the carry out of the 17-bit sum H + M, taken with no carry in.
- R7: In both modes, carry_o equals grp_g_o | (grp_p_o & carry_i).
- R8: eq_o is 1 exactly when result_o is all ones.
- R9: A build with LOOKAHEAD = 0 (ripple) and a build with LOOKAHEAD = 1 give identical outputs for every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| sel_i | input | 4 | Function select, shared by all slices |
| logic_mode_i | input | 1 | 1 = logic mode, 0 = arithmetic mode |
| carry_i | input | 1 | Carry into the least significant slice (active high) |
| result_o | output | 16 | Function result |
| carry_o | output | 1 | Carry out of the most significant slice |
| grp_p_o | output | 1 | Word-level group propagate |
| grp_g_o | output | 1 | Word-level group generate |
| eq_o | output | 1 | Result is all ones |

## Verification
The bench builds the default four slices of four bits twice, one instance with LOOKAHEAD = 1 and one with LOOKAHEAD = 0. Both instances take the same inputs. Every vector is scored against the bench model for each instance and also compared between the two instances, so a difference between the two carry variants is caught on any select, mode or operand pattern. Directed operands with long propagate runs force carries through all four slices, which puts the longest lookahead products and the full ripple chain within reach.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned SPAN_MAX = 32;
  localparam int unsigned GX_W     = SPAN_MAX + 1;

  // Carry into position pos: gx[0] is the incoming carry, gx[j] is generate of position j-1.
  // Expanded as a flat OR of AND terms (two-level lookahead).
  function automatic logic span_carry(input logic [GX_W-1:0] gx,
                                      input logic [SPAN_MAX-1:0] p,
                                      input int unsigned pos);
    logic acc;
    logic t;
    acc = 1'b0;
    for (int unsigned j = 0; j <= pos; j++) begin
      t = gx[j];
      for (int unsigned k = j; k < pos; k++) t = t & p[k];
      acc = acc | t;
    end
    return acc;
  endfunction
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu16_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             logic_mode_i,
  input  logic             c_i,
  output logic [W-1:0]     f_o,
  output logic             p_o,
  output logic             g_o,
  output logic             eq_o
);
  logic [W-1:0] h, m, cb;

  always_comb begin
    h = a_i | (b_i & {W{sel_i[0]}}) | (~b_i & {W{sel_i[1]}});
    m = (a_i & ~b_i & {W{sel_i[2]}}) | (a_i & b_i & {W{sel_i[3]}});
  end

  // Logic mode forces every internal carry high, giving ~(h ^ m).
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign cb[k] = logic_mode_i | span_carry(GX_W'({m, c_i}), SPAN_MAX'(h), k);
  end

  assign f_o  = h ^ m ^ cb;
  assign p_o  = &h;
  assign g_o  = span_carry(GX_W'({m, 1'b0}), SPAN_MAX'(h), W);
  assign eq_o = &f_o;
endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net
  import alu16_pkg::*;
#(
  parameter int unsigned N         = 4,
  parameter bit          LOOKAHEAD = 1'b1
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         c_i,
  output logic [N-1:0] cin_o,
  output logic         cout_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  logic [N:0] c;

  assign c[0] = c_i;

  if (LOOKAHEAD) begin : g_la
    for (genvar i = 1; i <= N; i++) begin : g_c
      assign c[i] = span_carry(GX_W'({g_i, c_i}), SPAN_MAX'(p_i), i);
    end
  end else begin : g_rip
    for (genvar i = 0; i < N; i++) begin : g_c
      assign c[i+1] = g_i[i] | (p_i[i] & c[i]);
    end
  end

  assign cin_o   = c[N-1:0];
  assign cout_o  = c[N];
  assign grp_p_o = &p_i;
  assign grp_g_o = span_carry(GX_W'({g_i, 1'b0}), SPAN_MAX'(p_i), N);
endmodule

// File: rtl/alu16_cascade.sv
module alu16_cascade
  import alu16_pkg::*;
#(
  parameter  int unsigned SLICE_W    = 4,
  parameter  int unsigned NUM_SLICES = 4,
  parameter  bit          LOOKAHEAD  = 1'b1,
  localparam int unsigned DATA_W     = SLICE_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              logic_mode_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              grp_p_o,
  output logic              grp_g_o,
  output logic              eq_o
);
  logic [NUM_SLICES-1:0] s_p, s_g, s_eq, s_cin;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    alu_slice #(.W(SLICE_W)) u_slice (
      .a_i         (a_i[i*SLICE_W +: SLICE_W]),
      .b_i         (b_i[i*SLICE_W +: SLICE_W]),
      .sel_i       (sel_i),
      .logic_mode_i(logic_mode_i),
      .c_i         (s_cin[i]),
      .f_o         (result_o[i*SLICE_W +: SLICE_W]),
      .p_o         (s_p[i]),
      .g_o         (s_g[i]),
      .eq_o        (s_eq[i])
    );
  end

  alu_carry_net #(.N(NUM_SLICES), .LOOKAHEAD(LOOKAHEAD)) u_carry (
    .p_i    (s_p),
    .g_i    (s_g),
    .c_i    (carry_i),
    .cin_o  (s_cin),
    .cout_o (carry_o),
    .grp_p_o(grp_p_o),
    .grp_g_o(grp_g_o)
  );

  assign eq_o = &s_eq;
endmodule

// File: rtl/alu16_cascade_chk.sv
module alu16_cascade_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [3:0]        sel_i,
  input logic              logic_mode_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              grp_p_o,
  input logic              grp_g_o,
  input logic              eq_o
);
  logic [DATA_W:0] add_ref, sub_ref;

  always_comb begin
    add_ref = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, carry_i};
    sub_ref = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, carry_i};
  end

  always_comb begin
    a_r7_carry_from_group: assert (carry_o == (grp_g_o | (grp_p_o & carry_i)))
      else $error("R7 carry_o inconsistent with group P/G");
    a_r8_eq_all_ones: assert (eq_o == (&result_o))
      else $error("R8 eq_o mismatch");
    a_r4_add: assert (!(!logic_mode_i && sel_i == 4'b1001) || {carry_o, result_o} == add_ref)
      else $error("R4 add mismatch");
    a_r4_sub: assert (!(!logic_mode_i && sel_i == 4'b0110) || {carry_o, result_o} == sub_ref)
      else $error("R4 subtract mismatch");
    a_r3_logic_xor: assert (!(logic_mode_i && sel_i == 4'b0110) || result_o == (a_i ^ b_i))
      else $error("R3 logic xor mismatch");
    a_r5_pass_a_propagate: assert (!(sel_i == 4'b0000) || grp_p_o == (&a_i))
      else $error("R5 group propagate mismatch");
  end
endmodule

bind alu16_cascade alu16_cascade_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_alu16_cascade.sv
module tb_alu16_cascade;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 16;
  localparam int unsigned WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a, b;
  logic [3:0] sel;
  logic lm, ci;

  logic [W-1:0] res_la, res_rp;
  logic co_la, co_rp, gp_la, gp_rp, gg_la, gg_rp, eq_la, eq_rp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_cascade #(.LOOKAHEAD(1'b1)) dut (
    .a_i(a), .b_i(b), .sel_i(sel), .logic_mode_i(lm), .carry_i(ci),
    .result_o(res_la), .carry_o(co_la), .grp_p_o(gp_la), .grp_g_o(gg_la), .eq_o(eq_la));

  alu16_cascade #(.LOOKAHEAD(1'b0)) dut_rip (
    .a_i(a), .b_i(b), .sel_i(sel), .logic_mode_i(lm), .carry_i(ci),
    .result_o(res_rp), .carry_o(co_rp), .grp_p_o(gp_rp), .grp_g_o(gg_rp), .eq_o(eq_rp));

  typedef struct packed {
    logic [W-1:0] res;
    logic co, gp, gg, eq;
  } exp_t;

  function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                 input logic [3:0] s, input logic l, input logic c);
    logic [W-1:0] h, m;
    logic [W:0] sum, gen;
    exp_t e;
    h   = x | (y & {W{s[0]}}) | (~y & {W{s[1]}});
    m   = (x & ~y & {W{s[2]}}) | (x & y & {W{s[3]}});
    sum = {1'b0, h} + {1'b0, m} + {{W{1'b0}}, c};
    gen = {1'b0, h} + {1'b0, m};
    e.res = l ? ~(h ^ m) : sum[W-1:0];
    e.co  = sum[W];
    e.gp  = &h;
    e.gg  = gen[W];
    e.eq  = &e.res;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h sel=%b lm=%b ci=%b)",
               req, act, expv, a, b, sel, lm, ci);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [3:0] s, input logic l, input logic c);
    @(posedge clk);
    a = x; b = y; sel = s; lm = l; ci = c;
    @(negedge clk);
  endtask

  task automatic check_all();
    exp_t e;
    e = model(a, b, sel, lm, ci);
    if (lm) chk(res_la == e.res, "R3 logic result", 32'(res_la), 32'(e.res));
    else    chk(res_la == e.res, "R2 arith result", 32'(res_la), 32'(e.res));
    chk(co_la == e.co, "R7 carry_o", 32'(co_la), 32'(e.co));
    chk(gp_la == e.gp, "R5 grp_p", 32'(gp_la), 32'(e.gp));
    chk(gg_la == e.gg, "R6 grp_g", 32'(gg_la), 32'(e.gg));
    chk(eq_la == e.eq, "R8 eq", 32'(eq_la), 32'(e.eq));
    chk({res_rp, co_rp, gp_rp, gg_rp, eq_rp} == {res_la, co_la, gp_la, gg_la, eq_la},
        "R9 ripple vs lookahead", 32'({res_rp, co_rp, gp_rp, gg_rp, eq_rp}),
        32'({res_la, co_la, gp_la, gg_la, eq_la}));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] r0;
    a = '0; b = '0; sel = '0; lm = 1'b0; ci = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Idle state: all-zero inputs pass A = 0 through
    chk(res_la == '0 && co_la == 1'b0 && eq_la == 1'b0, "R2 idle zero",
        32'({res_la, co_la, eq_la}), 32'd0);
    check_all();

    // R1: carry crosses every nibble boundary
    apply(16'hFFFF, 16'h0001, 4'b1001, 1'b0, 1'b0);
    chk({co_la, res_la} == 17'h10000, "R1 full carry chain", 32'({co_la, res_la}), 32'h10000);
    check_all();
    apply(16'h0FFF, 16'h0000, 4'b1001, 1'b0, 1'b1);
    chk({co_la, res_la} == 17'h01000, "R1 carry into top nibble", 32'({co_la, res_la}), 32'h01000);
    check_all();
    apply(16'h1234, 16'h4321, 4'b1001, 1'b0, 1'b0);
    chk(res_la == 16'h5555, "R1 per-nibble same op", 32'(res_la), 32'h5555);

    // R4: named operations
    apply(16'hA5C3, 16'h1F0E, 4'b1001, 1'b0, 1'b1);
    chk({co_la, res_la} == 17'(17'hA5C3 + 17'h1F0E + 17'h1), "R4 add",
        32'({co_la, res_la}), 32'(17'hA5C3 + 17'h1F0E + 17'h1));
    apply(16'h5000, 16'h1234, 4'b0110, 1'b0, 1'b1);
    chk(res_la == 16'(16'h5000 - 16'h1234), "R4 subtract", 32'(res_la), 32'(16'h5000 - 16'h1234));
    apply(16'h3C3C, 16'h0000, 4'b0110, 1'b0, 1'b0);
    chk(res_la == 16'(16'h3C3C - 16'h0001), "R4 subtract minus one", 32'(res_la), 32'(16'h3C3B));
    apply(16'h3C5A, 16'h0F0F, 4'b0000, 1'b1, 1'b0);
    chk(res_la == 16'hC3A5, "R4 not a", 32'(res_la), 32'hC3A5);
    apply(16'h3C5A, 16'h0F0F, 4'b1011, 1'b1, 1'b1);
    chk(res_la == 16'h0C0A, "R4 and", 32'(res_la), 32'h0C0A);
    apply(16'h3C5A, 16'h0F0F, 4'b1110, 1'b1, 1'b0);
    chk(res_la == 16'h3F5F, "R4 or", 32'(res_la), 32'h3F5F);
    apply(16'h3C5A, 16'h0F0F, 4'b0110, 1'b1, 1'b1);
    chk(res_la == 16'h3355, "R4 xor", 32'(res_la), 32'h3355);

    // R8: equal operands in subtract-minus-one give all ones
    apply(16'h7E81, 16'h7E81, 4'b0110, 1'b0, 1'b0);
    chk(eq_la == 1'b1 && res_la == 16'hFFFF, "R8 equal operands", 32'({eq_la, res_la}), 32'h1FFFF);
    apply(16'h7E81, 16'h7E80, 4'b0110, 1'b0, 1'b0);
    chk(eq_la == 1'b0, "R8 unequal operands", 32'(eq_la), 32'd0);

    // R5/R6/R7: propagate-only word, carry in decides carry out
    apply(16'hFFFF, 16'h0000, 4'b0000, 1'b0, 1'b1);
    chk(gp_la == 1'b1 && gg_la == 1'b0 && co_la == 1'b1, "R7 propagate passes carry",
        32'({gp_la, gg_la, co_la}), 32'b101);
    check_all();

    // R3: carry_i has no effect in logic mode
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] x, y;
      logic [3:0] s;
      x = W'($urandom); y = W'($urandom); s = 4'($urandom);
      apply(x, y, s, 1'b1, 1'b0);
      r0 = res_la;
      apply(x, y, s, 1'b1, 1'b1);
      chk(res_la == r0, "R3 carry_i ignored", 32'(res_la), 32'(r0));
    end

    // Random sweep
    for (int n = 0; n < 1500; n++) begin
      apply(W'($urandom), W'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
      check_all();
    end

    // Exhaustive select/mode/carry on long propagate patterns
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 4; k++) begin
        apply(16'hFFF0 | 16'(k), 16'h000F ^ 16'(k << 2), 4'(s), 1'(k >> 1), 1'(k));
        check_all();
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule